// File: doc/BRIEF.md
# Isochronous Endpoint Buffer-Ready Controller

This block manages the ready state of one isochronous endpoint in a USB device controller. It sits between the CPU register side and the serial interface engine (SIE) side of the endpoint FIFO. It does not store data. It only tracks byte counts, buffer ownership and when a packet may be sent.

In transmit (IN) mode the CPU loads a packet and then arms it in one of two ways. The first way sends it on the next IN token. The second way holds it until a start-of-frame has been seen, and sends it on the first IN token after that. A packet also arms itself when the CPU's byte writes reach the programmed maximum packet size.

In receive (OUT) mode the block raises a buffer-valid flag once received data is ready for the CPU. It lowers the flag when the CPU has read the last byte or issues a clear command. In double-buffer mode it swaps the SIE-side buffer to the CPU side as soon as the CPU side is empty.

Top module: `iso_rdy_ctl`

## Requirements
- R1: After reset, all outputs are 0: `txEnable`, `bufValid`, `bufReady` and `delayPend` are low, `cpuSel` selects buffer 0, and `byteCount` is 0.
- R2: With `dirIn`=1, a `wrValid` strobe raises `bufValid`/`bufReady` one cycle later. The next `inToken` raises `txEnable` one cycle after the token, and no start-of-frame is needed.
- R3: With `dirIn`=1, a `wrDelayStart` strobe raises `delayPend` one cycle later. Any `inToken` before the next `sofRx` is ignored and `txEnable` stays low. After a `sofRx`, the next `inToken` raises `txEnable` one cycle later.
- R4: A `txStart` strobe while `txEnable` is high drops `txEnable`, `delayPend` and `bufValid` and zeroes `byteCount`, all one cycle later.
- R5: In IN mode each `byteWr` adds one to `byteCount`. The write that makes `byteCount` equal to `maxPkt` raises `bufValid` one cycle later and arms the packet for the next IN token. Writes that stay below `maxPkt` leave `bufValid` low.
- R6: While `ctrlReq`=1, `bufValid` reads 0 and `bufReady` still shows the internal flag.
- R7: With `dirIn`=0 and `dualBuf`=0, `rxDone` raises `bufValid` one cycle later and loads `byteCount` with `rxLen`.
- R8: With `dirIn`=0 and `dualBuf`=1, a received packet passes to the CPU side only when the CPU side is empty. The swap comes one cycle after the SIE side fills, or one cycle after the CPU side empties, whichever is later. At the swap, `bufValid` rises, `byteCount` takes the received length and `cpuSel` flips.
- R9: In OUT mode a `wrToggle` strobe raises `bufValid` one cycle later.
- R10: In OUT mode each `byteRd` subtracts one from a nonzero `byteCount`. The read that takes the count from 1 to 0 drops `bufValid` one cycle later.
- R11: A `wrBufClr` or `wrAutoClr` strobe drops `bufValid`, `txEnable` and `delayPend` and zeroes `byteCount` one cycle later. Data waiting on the SIE side is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirIn | input | 1 | 1 = transmit (IN), 0 = receive (OUT) |
| dualBuf | input | 1 | 1 = double-buffer mode for OUT |
| ctrlReq | input | 1 | Control request pending; masks `bufValid` |
| maxPkt | input | CNT_W | Maximum packet size in bytes |
| rxLen | input | CNT_W | Length of the packet just received, valid with `rxDone` |
| sofRx | input | 1 | Start-of-frame received strobe |
| inToken | input | 1 | IN token received strobe |
| rxDone | input | 1 | SIE finished receiving a packet |
| txStart | input | 1 | SIE began sending the armed packet |
| wrDelayStart | input | 1 | CPU command: send after next start-of-frame |
| wrValid | input | 1 | CPU command: set buffer valid |
| wrToggle | input | 1 | CPU command: toggle / force valid in OUT mode |
| wrBufClr | input | 1 | CPU command: clear buffer |
| wrAutoClr | input | 1 | CPU command: auto-clear buffer |
| byteWr | input | 1 | CPU wrote one byte to the FIFO |
| byteRd | input | 1 | CPU read one byte from the FIFO |
| txEnable | output | 1 | Packet armed and qualifying token seen |
| bufValid | output | 1 | Buffer-valid as read by the CPU |
| bufReady | output | 1 | Endpoint buffer-ready status |
| delayPend | output | 1 | Delay-start command pending |
| cpuSel | output | 1 | Buffer currently owned by the CPU side |
| byteCount | output | CNT_W | CPU-side byte count |

## Verification
Almost every result is due one cycle after its strobe, because each output comes from a single register stage. The double-buffer swap is the exception: it needs a second cycle, since the SIE side must first register as full, or the CPU side as empty, before the swap fires.

The `ctrlReq` masking is combinational. It is still checked one cycle after the level changes, so that the check never reads an output in the same step the bench changes an input.

The driver stamps each expected value with the cycle it is due, computed from these latencies. The monitor compares it only at the falling edge of exactly that cycle. A result that arrives early or late is therefore reported as a mismatch.

// File: rtl/iso_rdy_pkg.sv
package iso_rdy_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_SOF,
    ST_ARMED,
    ST_SEND
  } txStateT;

  typedef struct packed {
    logic cntClr;
    logic cntLoadRx;
    logic swap;
    logic selFlip;
  } dpCmdT;

endpackage

// File: rtl/iso_rdy_dp.sv
module iso_rdy_dp
  import iso_rdy_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmdT            cmd,
  input  logic             dirIn,
  input  logic             dualBuf,
  input  logic             byteWr,
  input  logic             byteRd,
  input  logic             rxDone,
  input  logic [CNT_W-1:0] rxLen,
  input  logic [CNT_W-1:0] maxPkt,
  output logic [CNT_W-1:0] count,
  output logic             sieFull,
  output logic             cpuSel,
  output logic             fullHit,
  output logic             lastRd
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] countQ, countD;
  logic [CNT_W-1:0] sieLenQ, sieLenD;
  logic             sieFullQ, sieFullD;
  logic             selQ;
  logic             capture;
  logic [CNT_W:0]   nextWr;

  assign nextWr  = {1'b0, countQ} + {{CNT_W{1'b0}}, 1'b1};
  assign fullHit = dirIn && byteWr && (nextWr == {1'b0, maxPkt});
  assign lastRd  = !dirIn && byteRd && (countQ == CNT_ONE);
  assign capture = !dirIn && dualBuf && rxDone;

  always_comb begin
    countD = countQ;
    if (cmd.cntClr)                             countD = '0;
    else if (cmd.swap)                          countD = sieLenQ;
    else if (cmd.cntLoadRx)                     countD = rxLen;
    else if (dirIn && byteWr && countQ != CNT_MAX) countD = countQ + CNT_ONE;
    else if (!dirIn && byteRd && countQ != '0)  countD = countQ - CNT_ONE;
  end

  always_comb begin
    sieFullD = sieFullQ;
    sieLenD  = sieLenQ;
    if (cmd.swap) sieFullD = 1'b0;
    if (capture) begin
      sieFullD = 1'b1;
      sieLenD  = rxLen;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ   <= '0;
      sieLenQ  <= '0;
      sieFullQ <= 1'b0;
      selQ     <= 1'b0;
    end else begin
      countQ   <= countD;
      sieLenQ  <= sieLenD;
      sieFullQ <= sieFullD;
      if (cmd.selFlip) selQ <= !selQ;
    end
  end

  assign count   = countQ;
  assign sieFull = sieFullQ;
  assign cpuSel  = selQ;

  // R10: the final read empties the CPU-side count
  assert_last_read_empties_R10: assert property (@(posedge clk) disable iff (!rstN)
    (lastRd && !cmd.cntClr && !cmd.swap && !cmd.cntLoadRx) |=> (count == '0));

  // R8: a swap always hands over ownership and frees the SIE side
  assert_swap_frees_sie_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.swap && !capture) |=> (!sieFull && (cpuSel != $past(cpuSel))));

endmodule

// File: rtl/iso_rdy_ctrl.sv
module iso_rdy_ctrl
  import iso_rdy_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  dirIn,
  input  logic  dualBuf,
  input  logic  sofRx,
  input  logic  inToken,
  input  logic  rxDone,
  input  logic  txStart,
  input  logic  wrDelayStart,
  input  logic  wrValid,
  input  logic  wrToggle,
  input  logic  wrBufClr,
  input  logic  wrAutoClr,
  input  logic  sieFull,
  input  logic  fullHit,
  input  logic  lastRd,
  output dpCmdT cmd,
  output logic  validQ,
  output logic  delayQ,
  output logic  txEnable
);

  txStateT stateQ, stateD;
  logic    validD, delayD;
  logic    clr, txGo, swapNow, arm;

  assign clr     = wrBufClr || wrAutoClr;
  assign txGo    = dirIn && (stateQ == ST_SEND) && txStart;
  assign arm     = wrValid || fullHit;
  assign swapNow = !dirIn && dualBuf && sieFull && !validQ && !clr && !wrToggle;

  always_comb begin
    cmd.cntClr    = clr || txGo;
    cmd.swap      = swapNow;
    cmd.cntLoadRx = !dirIn && !dualBuf && rxDone && !clr;
    cmd.selFlip   = swapNow || (!dirIn && dualBuf && wrToggle && !clr);
  end

  always_comb begin
    validD = validQ;
    if (clr) begin
      validD = 1'b0;
    end else if (dirIn) begin
      if (txGo)     validD = 1'b0;
      else if (arm) validD = 1'b1;
    end else begin
      if (wrToggle || swapNow || (!dualBuf && rxDone)) validD = 1'b1;
      else if (lastRd)                                 validD = 1'b0;
    end
  end

  always_comb begin
    stateD = stateQ;
    if (clr || !dirIn) begin
      stateD = ST_IDLE;
    end else begin
      unique case (stateQ)
        ST_IDLE:     if (wrDelayStart)  stateD = ST_WAIT_SOF;
                     else if (arm)      stateD = ST_ARMED;
        ST_WAIT_SOF: if (sofRx || arm)  stateD = ST_ARMED;
        ST_ARMED:    if (inToken)       stateD = ST_SEND;
        ST_SEND:     if (txStart)       stateD = ST_IDLE;
        default:                        stateD = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    delayD = delayQ;
    if (clr || txGo || !dirIn) delayD = 1'b0;
    else if (wrDelayStart && stateQ == ST_IDLE) delayD = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      validQ <= 1'b0;
      delayQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      validQ <= validD;
      delayQ <= delayD;
    end
  end

  assign txEnable = (stateQ == ST_SEND);

  // R2: transmission is only enabled in response to an IN token
  assert_tx_after_token_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEnable) |-> $past(inToken));

  // R3: while waiting for a frame start, tokens cannot enable transmission
  assert_wait_blocks_token_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT_SOF && !sofRx && !arm) |=> !txEnable);

  // R4: the start of transmission retires the delay request and the enable
  assert_start_retires_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && txStart && dirIn) |=> (!delayQ && !txEnable && !validQ));

  // R7: single-buffer receive completion makes the buffer valid
  assert_single_rx_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!dirIn && !dualBuf && rxDone && !clr) |=> validQ);

  // R11: clear commands drop valid and transmit enable
  assert_clear_drops_R11: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (!validQ && !txEnable && !delayQ));

endmodule

// File: rtl/iso_rdy_ctl.sv
module iso_rdy_ctl
  import iso_rdy_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dirIn,
  input  logic             dualBuf,
  input  logic             ctrlReq,
  input  logic [CNT_W-1:0] maxPkt,
  input  logic [CNT_W-1:0] rxLen,
  input  logic             sofRx,
  input  logic             inToken,
  input  logic             rxDone,
  input  logic             txStart,
  input  logic             wrDelayStart,
  input  logic             wrValid,
  input  logic             wrToggle,
  input  logic             wrBufClr,
  input  logic             wrAutoClr,
  input  logic             byteWr,
  input  logic             byteRd,
  output logic             txEnable,
  output logic             bufValid,
  output logic             bufReady,
  output logic             delayPend,
  output logic             cpuSel,
  output logic [CNT_W-1:0] byteCount
);

  dpCmdT cmd;
  logic  sieFull, fullHit, lastRd, validQ;

  iso_rdy_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .dirIn(dirIn), .dualBuf(dualBuf),
    .sofRx(sofRx), .inToken(inToken), .rxDone(rxDone), .txStart(txStart),
    .wrDelayStart(wrDelayStart), .wrValid(wrValid), .wrToggle(wrToggle),
    .wrBufClr(wrBufClr), .wrAutoClr(wrAutoClr),
    .sieFull(sieFull), .fullHit(fullHit), .lastRd(lastRd),
    .cmd(cmd), .validQ(validQ), .delayQ(delayPend), .txEnable(txEnable)
  );

  iso_rdy_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .dirIn(dirIn), .dualBuf(dualBuf),
    .byteWr(byteWr), .byteRd(byteRd), .rxDone(rxDone), .rxLen(rxLen),
    .maxPkt(maxPkt), .count(byteCount), .sieFull(sieFull), .cpuSel(cpuSel),
    .fullHit(fullHit), .lastRd(lastRd)
  );

  assign bufReady = validQ;
  assign bufValid = validQ && !ctrlReq;

endmodule

// File: tb/iso_rdy_ctl_tb_top.sv
`timescale 1ns/1ps
module iso_rdy_ctl_tb_top;

  localparam int W = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, dirIn, dualBuf, ctrlReq;
  logic [W-1:0] maxPkt, rxLen;
  logic sofRx, inToken, rxDone, txStart, wrDelayStart, wrValid, wrToggle;
  logic wrBufClr, wrAutoClr, byteWr, byteRd;
  logic txEnable, bufValid, bufReady, delayPend, cpuSel;
  logic [W-1:0] byteCount;

  iso_rdy_ctl #(.CNT_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .dirIn(dirIn), .dualBuf(dualBuf), .ctrlReq(ctrlReq),
    .maxPkt(maxPkt), .rxLen(rxLen), .sofRx(sofRx), .inToken(inToken),
    .rxDone(rxDone), .txStart(txStart), .wrDelayStart(wrDelayStart),
    .wrValid(wrValid), .wrToggle(wrToggle), .wrBufClr(wrBufClr),
    .wrAutoClr(wrAutoClr), .byteWr(byteWr), .byteRd(byteRd),
    .txEnable(txEnable), .bufValid(bufValid), .bufReady(bufReady),
    .delayPend(delayPend), .cpuSel(cpuSel), .byteCount(byteCount)
  );

  typedef enum {S_TXEN, S_VALID, S_READY, S_DELAY, S_SEL, S_CNT} sigT;
  typedef struct {
    string rq;
    sigT   s;
    int    v;
    int    due;
  } itemT;

  itemT sb[$];
  int cyc = 0;
  int nRun = 0;
  int nFail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int peek(sigT s);
    case (s)
      S_TXEN:  return int'(txEnable);
      S_VALID: return int'(bufValid);
      S_READY: return int'(bufReady);
      S_DELAY: return int'(delayPend);
      S_SEL:   return int'(cpuSel);
      default: return int'(byteCount);
    endcase
  endfunction

  // monitor: compare each expectation in the cycle it is due
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        int act;
        act = peek(sb[i].s);
        nRun++;
        if (act != sb[i].v) begin
          nFail++;
          $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d",
                   sb[i].rq, sb[i].s.name(), act, sb[i].v, cyc);
        end
        sb.delete(i);
      end
    end
  end

  task automatic exp_(string rq, sigT s, int v, int d);
    itemT it;
    it.rq = rq; it.s = s; it.v = v; it.due = cyc + d;
    sb.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    rstN = 0; dirIn = 0; dualBuf = 0; ctrlReq = 0; maxPkt = '0; rxLen = '0;
    sofRx = 0; inToken = 0; rxDone = 0; txStart = 0; wrDelayStart = 0;
    wrValid = 0; wrToggle = 0; wrBufClr = 0; wrAutoClr = 0; byteWr = 0; byteRd = 0;
    repeat (3) tick();
    rstN = 1;
    // R1 reset state
    exp_("R1", S_TXEN, 0, 1); exp_("R1", S_VALID, 0, 1); exp_("R1", S_READY, 0, 1);
    exp_("R1", S_DELAY, 0, 1); exp_("R1", S_SEL, 0, 1); exp_("R1", S_CNT, 0, 1);
    tick(); tick();

    // R5 partial writes do not arm, R2 manual start
    dirIn = 1; maxPkt = 10'd8;
    tick();
    for (int k = 0; k < 3; k++) begin
      byteWr = 1;
      if (k == 2) begin exp_("R5", S_CNT, 3, 1); exp_("R5", S_VALID, 0, 1); end
      tick(); byteWr = 0;
    end
    wrValid = 1; exp_("R2", S_VALID, 1, 1); exp_("R2", S_READY, 1, 1); exp_("R2", S_TXEN, 0, 1);
    tick(); wrValid = 0;
    tick();
    inToken = 1; exp_("R2", S_TXEN, 1, 1);
    tick(); inToken = 0;
    txStart = 1; exp_("R4", S_TXEN, 0, 1); exp_("R4", S_VALID, 0, 1); exp_("R4", S_CNT, 0, 1);
    tick(); txStart = 0;
    tick();

    // R6 control request masks the readable flag
    wrValid = 1; tick(); wrValid = 0;
    ctrlReq = 1; exp_("R6", S_VALID, 0, 1); exp_("R6", S_READY, 1, 1);
    tick(); tick();
    ctrlReq = 0; exp_("R6", S_VALID, 1, 1);
    tick();
    // R11 buffer clear in IN mode
    wrBufClr = 1; exp_("R11", S_VALID, 0, 1); exp_("R11", S_READY, 0, 1); exp_("R11", S_CNT, 0, 1);
    tick(); wrBufClr = 0;
    inToken = 1; exp_("R11", S_TXEN, 0, 1);
    tick(); inToken = 0;
    tick();

    // R3 delayed start waits for a frame start
    wrDelayStart = 1; exp_("R3", S_DELAY, 1, 1); exp_("R3", S_TXEN, 0, 1);
    tick(); wrDelayStart = 0;
    inToken = 1; exp_("R3", S_TXEN, 0, 1); exp_("R3", S_TXEN, 0, 2);
    tick(); inToken = 0;
    tick();
    sofRx = 1; exp_("R3", S_TXEN, 0, 1);
    tick(); sofRx = 0;
    inToken = 1; exp_("R3", S_TXEN, 1, 1); exp_("R3", S_DELAY, 1, 1);
    tick(); inToken = 0;
    txStart = 1; exp_("R4", S_DELAY, 0, 1); exp_("R4", S_TXEN, 0, 1);
    tick(); txStart = 0;
    tick();

    // R5 write reaching max packet size arms automatically
    maxPkt = 10'd4;
    for (int k = 0; k < 4; k++) begin
      byteWr = 1;
      if (k == 2) exp_("R5", S_VALID, 0, 1);
      if (k == 3) begin exp_("R5", S_VALID, 1, 1); exp_("R5", S_CNT, 4, 1); end
      tick(); byteWr = 0;
    end
    inToken = 1; exp_("R5", S_TXEN, 1, 1);
    tick(); inToken = 0;
    txStart = 1; exp_("R4", S_CNT, 0, 1);
    tick(); txStart = 0;
    tick();

    // R7 single-buffer receive, R10 reads drain it
    dirIn = 0; dualBuf = 0;
    tick();
    rxLen = 10'd3; rxDone = 1; exp_("R7", S_VALID, 1, 1); exp_("R7", S_CNT, 3, 1);
    tick(); rxDone = 0;
    for (int k = 0; k < 3; k++) begin
      byteRd = 1;
      if (k == 1) begin exp_("R10", S_CNT, 1, 1); exp_("R10", S_VALID, 1, 1); end
      if (k == 2) begin exp_("R10", S_CNT, 0, 1); exp_("R10", S_VALID, 0, 1); end
      tick(); byteRd = 0;
    end
    // R9 toggle forces valid, R11 auto-clear drops it
    wrToggle = 1; exp_("R9", S_VALID, 1, 1);
    tick(); wrToggle = 0;
    wrAutoClr = 1; exp_("R11", S_VALID, 0, 1); exp_("R11", S_CNT, 0, 1);
    tick(); wrAutoClr = 0;
    tick();

    // R8 double buffer swap timing
    dualBuf = 1;
    tick();
    rxLen = 10'd5; rxDone = 1;
    exp_("R8", S_VALID, 0, 1); exp_("R8", S_VALID, 1, 2);
    exp_("R8", S_CNT, 5, 2); exp_("R8", S_SEL, 1, 2);
    tick(); rxDone = 0;
    tick();
    rxLen = 10'd2; rxDone = 1;
    exp_("R8", S_CNT, 5, 2); exp_("R8", S_SEL, 1, 2);
    tick(); rxDone = 0;
    tick();
    for (int k = 0; k < 5; k++) begin
      byteRd = 1;
      if (k == 4) begin
        exp_("R10", S_VALID, 0, 1);
        exp_("R8", S_VALID, 1, 2); exp_("R8", S_CNT, 2, 2); exp_("R8", S_SEL, 0, 2);
      end
      tick(); byteRd = 0;
    end
    repeat (4) tick();

    if (sb.size() != 0) begin
      nFail += sb.size();
      $display("FAIL R1 pending actual=%0d expected=0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule